// File: doc/BRIEF.md
# Line-Interleaved DMA Read Sequencer

This block turns one start pulse into the complete, ordered list of memory read requests needed to fetch an image frame for a compressed-pixel calibration path. Each image line needs one predictor seed word before its pixel data can be decoded. For every line the sequencer therefore first asks for that seed from a strided seed table. It then asks for the line's pixels in fixed 8-byte beats, from left to right.

Every request carries an address, a byte length and a 3-bit position tag. A downstream decoder uses the tag to tell seeds from pixels and to find frame and line boundaries. Requests leave under a valid/ready handshake. A one-cycle done pulse marks the end of the frame. The base addresses, strides, width and height are captured at start, so the caller may change them while a frame is running.

Top module: `lidma_rd_seq`

## Requirements
- R1: Each line starts with exactly one seed request. Its address is seed base + line index × seed stride and its tag is 0. It comes before any pixel request of that line.
- R2: A pixel request's address is pixel base + line index × pixel stride + horizontal byte offset.
- R3: Every request, seed or pixel, has a length of 8. The horizontal offset runs from 0 to width − 8 in steps of 8.
- R4: Lines are issued in order from 0 to height − 1. Within a line, the seed comes first and then the pixel offsets in ascending order.
- R5: Pixel tags: 2 is the first pixel of line 0, 3 is the first pixel of any other line, 4 is the last pixel of a line that is not the final line, 5 is the last pixel of the final line, and 1 is every other pixel.
- R6: When width is 8, the single pixel of a line is tagged as follows: 5 on the final line, otherwise 2 on line 0, otherwise 4. The end tags therefore take priority over tag 3.
- R7: While valid is high and ready is low, the request's address, length and tag stay unchanged. The sequence advances only on a cycle where valid and ready are both high.
- R8: One cycle after the tag-5 request is accepted, done is high for exactly one cycle and valid is low.
- R9: A start pulse that arrives while a frame is in progress has no effect. The frame finishes with its original settings and no extra requests follow.
- R10: A start pulse is ignored when width is zero, width is not a multiple of 8, or height is zero. No request is issued.
- R11: After reset, valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for one frame |
| seed_base_i | input | ADDR_W | Base address of the seed table |
| pix_base_i | input | ADDR_W | Base address of the pixel buffer |
| seed_stride_i | input | ADDR_W | Byte distance between the seeds of successive lines |
| pix_stride_i | input | ADDR_W | Byte distance between successive pixel lines |
| width_i | input | DIM_W | Line width in bytes |
| height_i | input | DIM_W | Number of lines |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted by the memory side |
| req_addr_o | output | ADDR_W | Request byte address |
| req_len_o | output | LEN_W | Request length in bytes (always 8) |
| req_tag_o | output | 3 | Position tag |
| done_o | output | 1 | One-cycle pulse after the frame's last request is accepted |

## Verification
On every cycle the assertions check the following:
- a stalled request does not change;
- a seed acceptance is followed by a pixel request;
- done only follows acceptance of a frame-end request, and lasts a single cycle;
- the column counter stays aligned and within the line;
- the line steps only after a line's last beat.

Only the bench's scenarios can show that whole addresses and tags match the arithmetic for each width, height and stride, including the single-beat-per-line priority. The same applies to the rule that a start during a frame or with bad settings leaves the stream untouched. The bench sweeps small widths and heights both with a ready that is always high and with a ready that stalls on a pseudo-random pattern.

// File: rtl/lidma_pkg.sv
package lidma_pkg;

    localparam int unsigned BEAT_BYTES = 8;
    localparam int unsigned BEAT_SHIFT = 3;
    localparam int unsigned TAG_W      = 3;

    typedef enum logic [TAG_W-1:0] {
        TAG_SEED   = 3'd0,
        TAG_DATA   = 3'd1,
        TAG_FSTART = 3'd2,
        TAG_LSTART = 3'd3,
        TAG_LEND   = 3'd4,
        TAG_FEND   = 3'd5
    } tag_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEED = 2'd1,
        PH_PIX  = 2'd2
    } phase_e;

endpackage

// File: rtl/lidma_pos_ctr.sv
module lidma_pos_ctr #(
    parameter int unsigned DIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             col_step_i,
    input  logic             line_step_i,
    input  logic [DIM_W-1:0] width_i,
    input  logic [DIM_W-1:0] height_i,
    output logic [DIM_W-1:0] col_o,
    output logic             first_col_o,
    output logic             last_col_o,
    output logic             first_line_o,
    output logic             last_line_o
);
    localparam logic [DIM_W-1:0] STEP = DIM_W'(lidma_pkg::BEAT_BYTES);
    localparam logic [DIM_W-1:0] ONE  = DIM_W'(1);

    typedef struct packed {
        logic [DIM_W-1:0] col;
        logic [DIM_W-1:0] line;
        logic [DIM_W-1:0] col_end;
        logic [DIM_W-1:0] line_end;
    } pos_t;

    pos_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.col      = '0;
            st_d.line     = '0;
            st_d.col_end  = width_i - STEP;
            st_d.line_end = height_i - ONE;
        end else if (line_step_i) begin
            st_d.col  = '0;
            st_d.line = st_q.line + ONE;
        end else if (col_step_i) begin
            st_d.col = st_q.col + STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col_o        = st_q.col;
    assign first_col_o  = (st_q.col == '0);
    assign last_col_o   = (st_q.col == st_q.col_end);
    assign first_line_o = (st_q.line == '0);
    assign last_line_o  = (st_q.line == st_q.line_end);

    AST_COL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.col[lidma_pkg::BEAT_SHIFT-1:0] == '0);                          // R3
    AST_COL_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.col <= st_q.col_end);                                           // R3
    AST_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.line <= st_q.line_end);                                         // R4
    AST_LINE_STEP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        line_step_i |-> (last_col_o && !last_line_o));                       // R4
    AST_COL_STEP_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        col_step_i |-> !last_col_o);                                         // R3

endmodule

// File: rtl/lidma_addr_acc.sv
module lidma_addr_acc #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              line_step_i,
    input  logic [ADDR_W-1:0] seed_base_i,
    input  logic [ADDR_W-1:0] pix_base_i,
    input  logic [ADDR_W-1:0] seed_stride_i,
    input  logic [ADDR_W-1:0] pix_stride_i,
    output logic [ADDR_W-1:0] seed_line_o,
    output logic [ADDR_W-1:0] pix_line_o
);
    localparam int unsigned NCH   = 2;
    localparam int unsigned CH_SD = 0;
    localparam int unsigned CH_PX = 1;

    typedef struct packed {
        logic [NCH-1:0][ADDR_W-1:0] line_addr;
        logic [NCH-1:0][ADDR_W-1:0] stride;
    } acc_t;

    acc_t st_d, st_q;
    logic [NCH-1:0][ADDR_W-1:0] base_in, stride_in;

    assign base_in[CH_SD]   = seed_base_i;
    assign base_in[CH_PX]   = pix_base_i;
    assign stride_in[CH_SD] = seed_stride_i;
    assign stride_in[CH_PX] = pix_stride_i;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NCH; c++) begin
            if (load_i) begin
                st_d.line_addr[c] = base_in[c];
                st_d.stride[c]    = stride_in[c];
            end else if (line_step_i) begin
                st_d.line_addr[c] = st_q.line_addr[c] + st_q.stride[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seed_line_o = st_q.line_addr[CH_SD];
    assign pix_line_o  = st_q.line_addr[CH_PX];

    AST_STRIDE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(st_q.stride));                                   // R2
    AST_SEED_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && line_step_i) |=>
            (seed_line_o == $past(seed_line_o) + $past(st_q.stride[CH_SD]))); // R1

endmodule

// File: rtl/lidma_tag_enc.sv
module lidma_tag_enc (
    input  logic       is_seed_i,
    input  logic       first_col_i,
    input  logic       last_col_i,
    input  logic       first_line_i,
    input  logic       last_line_i,
    output logic [2:0] tag_o
);
    lidma_pkg::tag_e tag;

    always_comb begin
        if (is_seed_i)                        tag = lidma_pkg::TAG_SEED;
        else if (last_col_i && last_line_i)   tag = lidma_pkg::TAG_FEND;
        else if (first_col_i && first_line_i) tag = lidma_pkg::TAG_FSTART;
        else if (last_col_i)                  tag = lidma_pkg::TAG_LEND;
        else if (first_col_i)                 tag = lidma_pkg::TAG_LSTART;
        else                                  tag = lidma_pkg::TAG_DATA;
    end

    assign tag_o = tag;

endmodule

// File: rtl/lidma_rd_seq.sv
module lidma_rd_seq #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DIM_W  = 16,
    parameter int unsigned LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] seed_base_i,
    input  logic [ADDR_W-1:0] pix_base_i,
    input  logic [ADDR_W-1:0] seed_stride_i,
    input  logic [ADDR_W-1:0] pix_stride_i,
    input  logic [DIM_W-1:0]  width_i,
    input  logic [DIM_W-1:0]  height_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [LEN_W-1:0]  req_len_o,
    output logic [2:0]        req_tag_o,
    output logic              done_o
);
    import lidma_pkg::*;

    localparam int unsigned LSB_W = BEAT_SHIFT;

    typedef struct packed {
        phase_e phase;
        logic   done;
    } ctl_t;

    ctl_t st_d, st_q;

    logic              cfg_ok, launch, hs;
    logic              col_step, line_step;
    logic [DIM_W-1:0]  col;
    logic              first_col, last_col, first_line, last_line;
    logic [ADDR_W-1:0] seed_line, pix_line;

    assign cfg_ok = (width_i != '0) && (width_i[LSB_W-1:0] == '0) && (height_i != '0);
    assign launch = (st_q.phase == PH_IDLE) && start_i && cfg_ok;
    assign hs     = req_valid_o && req_ready_i;

    assign col_step  = hs && (st_q.phase == PH_PIX) && !last_col;
    assign line_step = hs && (st_q.phase == PH_PIX) && last_col && !last_line;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: if (launch) st_d.phase = PH_SEED;
            PH_SEED: if (hs)     st_d.phase = PH_PIX;
            PH_PIX: begin
                if (hs && last_col) begin
                    if (last_line) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.phase = PH_SEED;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    lidma_pos_ctr #(.DIM_W(DIM_W)) pos_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (launch),
        .col_step_i   (col_step),
        .line_step_i  (line_step),
        .width_i      (width_i),
        .height_i     (height_i),
        .col_o        (col),
        .first_col_o  (first_col),
        .last_col_o   (last_col),
        .first_line_o (first_line),
        .last_line_o  (last_line)
    );

    lidma_addr_acc #(.ADDR_W(ADDR_W)) acc_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (launch),
        .line_step_i   (line_step),
        .seed_base_i   (seed_base_i),
        .pix_base_i    (pix_base_i),
        .seed_stride_i (seed_stride_i),
        .pix_stride_i  (pix_stride_i),
        .seed_line_o   (seed_line),
        .pix_line_o    (pix_line)
    );

    lidma_tag_enc tag_i (
        .is_seed_i    (st_q.phase == PH_SEED),
        .first_col_i  (first_col),
        .last_col_i   (last_col),
        .first_line_i (first_line),
        .last_line_i  (last_line),
        .tag_o        (req_tag_o)
    );

    assign req_valid_o = (st_q.phase != PH_IDLE);
    assign req_addr_o  = (st_q.phase == PH_SEED) ? seed_line : (pix_line + ADDR_W'(col));
    assign req_len_o   = LEN_W'(BEAT_BYTES);
    assign done_o      = st_q.done;

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=>
            (req_valid_o && $stable(req_addr_o) && $stable(req_tag_o)));     // R7
    AST_SEED_THEN_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && req_tag_o == TAG_SEED) |=> (req_valid_o && req_tag_o != TAG_SEED)); // R1
    AST_DONE_FOLLOWS_FEND: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(hs && req_tag_o == TAG_FEND));                      // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                 // R8
    AST_FEND_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && req_tag_o == TAG_FEND) |=> (!req_valid_o && done_o));         // R8
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && req_valid_o && !hs) |=> (req_valid_o && $stable(req_addr_o))); // R9

endmodule

// File: tb/lidma_rd_seq_tb_top.sv
module lidma_rd_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] seed_base_i = '0, pix_base_i = '0, seed_stride_i = '0, pix_stride_i = '0;
    logic [15:0] width_i = '0, height_i = '0;
    logic        req_valid_o, req_ready_i = 1'b0;
    logic [31:0] req_addr_o;
    logic [3:0]  req_len_o;
    logic [2:0]  req_tag_o;
    logic        done_o;

    int n_chk = 0, n_fail = 0, cycles = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    lidma_rd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .seed_base_i(seed_base_i), .pix_base_i(pix_base_i),
        .seed_stride_i(seed_stride_i), .pix_stride_i(pix_stride_i),
        .width_i(width_i), .height_i(height_i),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_addr_o(req_addr_o), .req_len_o(req_len_o),
        .req_tag_o(req_tag_o), .done_o(done_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_fail = n_fail + 1;
            n_chk  = n_chk + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_tag(int x, int y, int w, int h);
        bit first = (x == 0), last = (x == w - 8), ll = (y == h - 1);
        if (last && ll)           return 3'd5;
        if (first && y == 0)      return 3'd2;
        if (last)                 return 3'd4;
        if (first)                return 3'd3;
        return 3'd1;
    endfunction

    task automatic run_frame(int w, int h, int mode, bit poke, int id);
        logic [31:0] sb = 32'h1000_0000 + 32'(id) * 32'h100;
        logic [31:0] pb = 32'h2000_0000 + 32'(id) * 32'h1_0000;
        logic [31:0] ss = 32'h10 + 32'(id) * 4;
        logic [31:0] ps = 32'(w) * 3 + 32'h40;
        int beats = 0;
        bit bail = 0;
        @(negedge clk);
        seed_base_i = sb; pix_base_i = pb; seed_stride_i = ss; pix_stride_i = ps;
        width_i = 16'(w); height_i = 16'(h); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int y = 0; y < h && !bail; y++) begin
            for (int k = -1; k < w / 8 && !bail; k++) begin
                logic [31:0] ea;
                logic [2:0]  et;
                int guard = 0;
                bit stalled = 0;
                if (k < 0) begin ea = sb + 32'(y) * ss; et = 3'd0; end
                else begin ea = pb + 32'(y) * ps + 32'(k * 8); et = exp_tag(k * 8, y, w, h); end
                forever begin
                    @(negedge clk);
                    start_i = 1'b0;
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    req_ready_i = (mode == 0) ? 1'b1 : lfsr[0];
                    if (poke && y == 0 && k == 0 && guard == 0) begin
                        // R9: start while busy, with different settings
                        start_i = 1'b1; width_i = 16'd8; height_i = 16'd1; seed_base_i = '0;
                    end
                    chk("R4 valid during frame", 64'(req_valid_o), 64'd1);
                    if (k < 0) chk(stalled ? "R7 seed hold" : "R1 seed address", 64'(req_addr_o), 64'(ea));
                    else       chk(stalled ? "R7 pixel hold" : "R2 pixel address", 64'(req_addr_o), 64'(ea));
                    chk("R3 length", 64'(req_len_o), 64'd8);
                    if (k < 0)       chk("R1 seed tag", 64'(req_tag_o), 64'(et));
                    else if (w == 8) chk("R6 single-beat tag", 64'(req_tag_o), 64'(et));
                    else             chk("R5 pixel tag", 64'(req_tag_o), 64'(et));
                    if (req_valid_o && req_ready_i) break;
                    stalled = 1;
                    guard++;
                    if (guard > 64) begin
                        chk("R7 stall too long", 64'(guard), 64'd0);
                        bail = 1;
                        break;
                    end
                end
                beats++;
            end
        end
        @(negedge clk);
        start_i = 1'b0;
        req_ready_i = 1'b0;
        chk("R8 done after frame end", 64'(done_o), 64'd1);
        chk("R8 valid low after frame", 64'(req_valid_o), 64'd0);
        @(negedge clk);
        chk("R8 done one cycle", 64'(done_o), 64'd0);
        chk("R9 no extra request", 64'(req_valid_o), 64'd0);
        chk("R9 beats issued", 64'(beats), 64'(h * (w / 8 + 1)));
    endtask

    task automatic bad_start(int w, int h);
        @(negedge clk);
        width_i = 16'(w); height_i = 16'(h); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R10 bad config ignored", 64'(req_valid_o), 64'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        int id = 0;
        repeat (3) @(negedge clk);
        chk("R11 valid after reset", 64'(req_valid_o), 64'd0);
        chk("R11 done after reset", 64'(done_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 valid idle", 64'(req_valid_o), 64'd0);
        for (int m = 0; m < 2; m++) begin
            for (int wi = 1; wi <= 5; wi++) begin
                for (int h = 1; h <= 3; h++) begin
                    run_frame(wi * 8, h, m, (h == 2), id);
                    id++;
                end
            end
        end
        bad_start(12, 2);
        bad_start(0, 2);
        bad_start(16, 0);
        run_frame(16, 2, 1, 1'b0, id);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule